// File: doc/BRIEF.md
# Grayscale Frame Rate Controller

This block turns a per-pixel gray code into the single on/off drive bit that a monochrome panel understands. It does so by temporal dithering. Across a repeating cycle of 16 frames, each pixel is switched on in a number of frames equal to its density level. The viewer's eye integrates those frames into an intermediate shade.

A gray code does not set the density directly. It first passes through a programmable palette with one entry per gray code. This lets the grayscale response be tuned to the crystal and drive voltage of a particular panel. Software writes new palette entries into a shadow copy, and that copy takes effect only at the next frame-start strobe, so a frame is never drawn with a half-updated palette.

Inside the cycle, the choice of which frames light a pixel comes from a bit-reversed frame phase. That phase is offset by the low bits of the pixel's column and row. The offset means neighbouring pixels of the same shade light in different frames, which spreads the flicker out in space.

Top module: `frc_gray_top`

## Requirements
- R1: After synchronous reset, `pix_on` and `pix_on_valid` are low, the frame counter is 0, and palette entry g holds the value g for every gray code g. Entries are 5 bits wide.
- R2: A pixel presented with `pix_valid` high produces its drive bit on `pix_on` with `pix_on_valid` high one clock later. When `pix_on_valid` is low, `pix_on` is low.
- R3: The 4-bit frame counter increments by one, modulo 16, on every clock in which `frame_start` is high, and holds its value otherwise.
- R4: Let f be the frame counter value in the cycle the pixel is presented, and let phase = (f + pix_x + pix_y) mod 16. Let rev(phase) be phase with its 4 bits reversed, so that bit 0 swaps with bit 3 and bit 1 swaps with bit 2. For a palette entry value v in the range 0..15, the pixel is on exactly when rev(phase) < v.
- R5: For a fixed pixel position and palette entry v in 0..15, the pixel is on in exactly v of any 16 consecutive frames.
- R6: An entry of 0 keeps the pixel off in every frame. An entry of 31 (all ones) keeps the pixel on in every frame. Entries 16 to 30 act as density 15.
- R7: When `pal_we` is high, `pal_wdata` is written to the shadow copy of entry `pal_idx`. This write has no effect on `pix_on` until the next `frame_start`.
- R8: On a clock with `frame_start` high, the active palette takes the shadow contents as they stood before that clock. A write issued in the same clock reaches the shadow copy only, so it takes effect at the following `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe marking a new frame |
| pix_valid | input | 1 | Pixel inputs are valid this cycle |
| pix_gray | input | 4 | Pixel gray code |
| pix_x | input | PHASE_W (4) | Low bits of the pixel column |
| pix_y | input | PHASE_W (4) | Low bits of the pixel row |
| pal_we | input | 1 | Palette shadow write enable |
| pal_idx | input | 4 | Gray code whose entry is written |
| pal_wdata | input | 5 | New palette entry value |
| pix_on | output | 1 | Drive bit for the pixel |
| pix_on_valid | output | 1 | `pix_on` carries a result |

## Verification
The bench first walks a table of positions and gray codes and compares each result against the bit-reversed phase rule. An error in the phase sum or in the bit reversal would show up as a wrong bit at particular positions. It then counts on-frames over a full 16-frame cycle for several densities. A pattern that repeats or skips phases would give the wrong count.

Palette timing is probed directly. The bench checks that a shadow write leaves the output unchanged before the next frame start. It also checks that a write issued in the same clock as the strobe slips by one frame; a design that copied the post-write value would switch a frame early. The bench also covers the extreme entries 0, 20 and 31, which a design could misdecode by treating 31 as density 15 or by wrapping 20 down to 4.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int GRAY_W   = 4;
    localparam int NUM_GRAY = 1 << GRAY_W;
    localparam int DENS_W   = 4;
    localparam int ENTRY_W  = DENS_W + 1;
    localparam int FRAME_W  = 4;

    typedef logic [ENTRY_W-1:0] pal_entry_t;
    typedef logic [FRAME_W-1:0] phase_t;

    typedef struct packed {
        logic              force_on;
        logic [DENS_W-1:0] density;
    } dens_t;

    // Map a palette entry to a density: all ones forces on, values above
    // the density range saturate at the top density.
    function automatic dens_t decode_entry(pal_entry_t e);
        dens_t d;
        d.force_on = &e;
        d.density  = e[ENTRY_W-1] ? {DENS_W{1'b1}} : e[DENS_W-1:0];
        return d;
    endfunction

    function automatic phase_t bit_reverse(phase_t p);
        phase_t r;
        for (int i = 0; i < FRAME_W; i++) begin
            r[i] = p[FRAME_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/frc_frame_counter.sv
module frc_frame_counter
    import frc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_start,
    output phase_t count
);

    phase_t count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (frame_start) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/frc_palette.sv
module frc_palette
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              wr_en,
    input  logic [GRAY_W-1:0] wr_idx,
    input  pal_entry_t        wr_data,
    input  logic [GRAY_W-1:0] rd_idx,
    output pal_entry_t        rd_entry
);

    pal_entry_t shadow_q [NUM_GRAY];
    pal_entry_t active_q [NUM_GRAY];

    for (genvar g = 0; g < NUM_GRAY; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[g] <= pal_entry_t'(g);
            end else if (wr_en && wr_idx == GRAY_W'(g)) begin
                shadow_q[g] <= wr_data;
            end
        end

        // Active copy picks up the pre-edge shadow value at the frame boundary.
        always_ff @(posedge clk) begin
            if (rst) begin
                active_q[g] <= pal_entry_t'(g);
            end else if (frame_start) begin
                active_q[g] <= shadow_q[g];
            end
        end
    end

    assign rd_entry = active_q[rd_idx];

endmodule

// File: rtl/frc_dither.sv
module frc_dither
    import frc_pkg::*;
(
    input  phase_t     frame,
    input  phase_t     pos_x,
    input  phase_t     pos_y,
    input  pal_entry_t entry,
    output logic       on
);

    phase_t phase;
    phase_t spread;
    dens_t  dens;

    always_comb begin
        phase  = frame + pos_x + pos_y;
        spread = bit_reverse(phase);
        dens   = decode_entry(entry);
        on     = dens.force_on || (spread < phase_t'(dens.density));
    end

endmodule

// File: rtl/frc_gray_top.sv
module frc_gray_top
    import frc_pkg::*;
#(
    parameter int PHASE_W = FRAME_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               pix_valid,
    input  logic [GRAY_W-1:0]  pix_gray,
    input  logic [PHASE_W-1:0] pix_x,
    input  logic [PHASE_W-1:0] pix_y,
    input  logic               pal_we,
    input  logic [GRAY_W-1:0]  pal_idx,
    input  logic [ENTRY_W-1:0] pal_wdata,
    output logic               pix_on,
    output logic               pix_on_valid
);

    phase_t     frame_cnt;
    pal_entry_t cur_entry;
    logic       dith_on;
    logic       on_q;
    logic       valid_q;

    frc_frame_counter u_frm (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .count       (frame_cnt)
    );

    frc_palette u_pal (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .wr_en       (pal_we),
        .wr_idx      (pal_idx),
        .wr_data     (pal_wdata),
        .rd_idx      (pix_gray),
        .rd_entry    (cur_entry)
    );

    frc_dither u_dith (
        .frame (frame_cnt),
        .pos_x (phase_t'(pix_x)),
        .pos_y (phase_t'(pix_y)),
        .entry (cur_entry),
        .on    (dith_on)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q    <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            on_q    <= pix_valid && dith_on;
            valid_q <= pix_valid;
        end
    end

    assign pix_on       = on_q;
    assign pix_on_valid = valid_q;

endmodule

// File: rtl/frc_gray_chk.sv
module frc_gray_chk
    import frc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        frame_start,
    input logic        pix_valid,
    input phase_t      frame_cnt,
    input pal_entry_t  cur_entry,
    input logic        pix_on,
    input logic        pix_on_valid
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> pix_on_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> !pix_on_valid);

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !pix_on_valid |-> !pix_on);

    // R3
    frame_step_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> frame_cnt == FRAME_W'($past(frame_cnt) + 1'b1));

    // R3
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(frame_cnt));

    // R6
    zero_off_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && cur_entry == '0) |=> !pix_on);

    // R6
    full_on_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && cur_entry == '1) |=> pix_on);

endmodule

bind frc_gray_top frc_gray_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .pix_valid    (pix_valid),
    .frame_cnt    (frame_cnt),
    .cur_entry    (cur_entry),
    .pix_on       (pix_on),
    .pix_on_valid (pix_on_valid)
);

// File: tb/frc_gray_top_tb_top.sv
module frc_gray_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       frame_start;
    logic       pix_valid;
    logic [3:0] pix_gray;
    logic [3:0] pix_x;
    logic [3:0] pix_y;
    logic       pal_we;
    logic [3:0] pal_idx;
    logic [4:0] pal_wdata;
    logic       pix_on;
    logic       pix_on_valid;

    int checks = 0;
    int errors = 0;
    int bframe = 0;

    always #10 clk = ~clk;

    frc_gray_top dut_i (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_gray(pix_gray), .pix_x(pix_x), .pix_y(pix_y),
        .pal_we(pal_we), .pal_idx(pal_idx), .pal_wdata(pal_wdata),
        .pix_on(pix_on), .pix_on_valid(pix_on_valid)
    );

    // {gray[4], x[4], y[4], expected[1]} at frame 0 with the reset palette
    localparam logic [12:0] VEC [10] = '{
        {4'd8,  4'd0, 4'd0, 1'b1},
        {4'd8,  4'd1, 4'd0, 1'b0},
        {4'd1,  4'd2, 4'd0, 1'b0},
        {4'd5,  4'd2, 4'd1, 1'b0},
        {4'd5,  4'd4, 4'd0, 1'b1},
        {4'd15, 4'd7, 4'd8, 1'b0},
        {4'd15, 4'd3, 4'd3, 1'b1},
        {4'd0,  4'd0, 4'd0, 1'b0},
        {4'd13, 4'd4, 4'd0, 1'b1},
        {4'd9,  4'd8, 4'd5, 1'b0}
    };

    function automatic logic rule(int f, int x, int y, int v);
        logic [3:0] ph;
        logic [3:0] rv;
        if (v == 31) return 1'b1;
        if (v > 15) v = 15;
        ph = 4'((f + x + y) % 16);
        rv = {ph[0], ph[1], ph[2], ph[3]};
        return int'(rv) < v;
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic pix(int g, int x, int y, output logic r);
        @(negedge clk);
        pix_valid = 1'b1; pix_gray = 4'(g); pix_x = 4'(x); pix_y = 4'(y);
        @(negedge clk);
        pix_valid = 1'b0;
        if (pix_on_valid !== 1'b1) begin
            checks++; errors++;
            $display("FAIL R2 actual=%0b expected=1", pix_on_valid);
        end
        r = pix_on;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        bframe = (bframe + 1) % 16;
    endtask

    task automatic wr(int idx, int d, logic with_frame);
        @(negedge clk);
        pal_we = 1'b1; pal_idx = 4'(idx); pal_wdata = 5'(d);
        frame_start = with_frame;
        @(negedge clk);
        pal_we = 1'b0; frame_start = 1'b0;
        if (with_frame) bframe = (bframe + 1) % 16;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic r;
        int cnt;
        rst = 1'b1; frame_start = 0; pix_valid = 0; pix_gray = 0;
        pix_x = 0; pix_y = 0; pal_we = 0; pal_idx = 0; pal_wdata = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 on", pix_on, 1'b0);
        check("R1 valid", pix_on_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 idle valid", pix_on_valid, 1'b0);

        // R4 table walk at frame 0, identity palette (R1)
        for (int i = 0; i < 10; i++) begin
            pix(int'(VEC[i][12:9]), int'(VEC[i][8:5]), int'(VEC[i][4:1]), r);
            check("R4 table", r, VEC[i][0]);
        end

        // R3/R4/R5 count over 16 frames for several densities and positions
        for (int g = 0; g < 16; g += 3) begin
            cnt = 0;
            for (int k = 0; k < 16; k++) begin
                pix(g, g + 1, 2 * g, r);
                check("R4 frame rule", r, rule(bframe, g + 1, 2 * g, g));
                if (r) cnt++;
                frame();
            end
            check("R5 count", cnt == g, 1'b1);
        end

        // R7 shadow write does not act before frame_start
        wr(6, 0, 1'b0);
        pix(6, 0, 0, r);
        check("R7 before frame", r, rule(bframe, 0, 0, 6));
        for (int k = 0; k < 16; k++) begin
            if (rule(bframe, 0, 0, 6)) break;
            frame();
        end
        wr(6, 0, 1'b0);
        pix(6, 0, 0, r);
        check("R7 unchanged", r, 1'b1);
        frame();
        // R6 entry 0 never on
        cnt = 0;
        for (int k = 0; k < 16; k++) begin
            pix(6, k, 3, r);
            if (r) cnt++;
            frame();
        end
        check("R6 zero off", cnt == 0, 1'b1);

        // R6 entry 31 always on, entry 20 behaves as 15
        wr(2, 31, 1'b0);
        wr(3, 20, 1'b0);
        frame();
        cnt = 0;
        for (int k = 0; k < 16; k++) begin
            pix(2, 5, 9, r);
            if (r) cnt++;
            pix(3, 5, 9, r);
            check("R6 saturate", r, rule(bframe, 5, 9, 15));
            frame();
        end
        check("R6 full on", cnt == 16, 1'b1);

        // R8 write coinciding with frame_start lands one frame late
        wr(4, 31, 1'b0);
        frame();
        wr(4, 0, 1'b1);
        pix(4, 1, 1, r);
        check("R8 old value kept", r, 1'b1);
        frame();
        pix(4, 1, 1, r);
        check("R8 new value", r, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule